// File: doc/BRIEF.md
# Double-Buffered Frame Overhead Register Bank

This block sits between a line framer and a small register port of a host processor. It carries the per-frame overhead and Z bits in both directions. On the transmit side, software fills a set of user registers. At each transmit frame boundary the whole set is copied into a hidden shift copy. The copy is then sent out one bit per overhead slot for the rest of the frame. Software can rewrite the user registers during that frame without disturbing the bits already in flight.

On the receive side, incoming overhead bits are collected into a hidden copy, one per receive slot. At the next receive frame boundary the complete word moves into read-only user registers. Each transfer raises a status flag that can drive an interrupt. Software then has one frame period to refill the transmit set or read the receive set before the next boundary replaces it.

The user overhead registers are reachable only while a parallel-access select bit is set. Bit positions that the link predefines are write-protected. The one exception is the indicator-request bit, which stays writable.

Top module: `ovh_dbuf_regs`

## Requirements
- R1: After reset, every register (select 0x24, enable 0x3E, status 0x3F, transmit and receive user registers) reads 0, and `irq` and `tx_bit` are 0.
- R2: While bit 0 of the select register (0x24) is 0, writes to the transmit user registers (0x10 for word bits 7:0, 0x11 for bits 15:8) are ignored. Reads of 0x10, 0x11, 0x18 and 0x19 return 0 in that state.
- R3: Word bits 4, 6 and 7 are predefined and always read 0 from 0x10, whatever is written. Word bit 5 (indicator request) and all other bits take the written value.
- R4: A cycle with `tx_slot` and `tx_frame` both high copies the transmit user word into the shift copy. User writes made after that copy do not change the bits sent in the same frame.
- R5: `tx_bit` is registered. In the cycle after the k-th `tx_slot` strobe of a frame, it shows word bit k. The strobe carrying `tx_frame` is k = 0, and bit k is bit k mod 8 of register 0x10 + k/8. Strobes past slot 15 give 0, and `tx_bit` holds its value when there is no strobe.
- R6: The k-th `rx_slot` strobe of a frame stores `rx_bit` as word bit k, where the strobe with `rx_frame` is k = 0. Strobes past slot 15 are dropped. The next `rx_frame` strobe moves the whole word to 0x18 (bits 7:0) and 0x19 (bits 15:8), readable from the next cycle. Between boundaries those registers do not change.
- R7: The first `rx_frame` strobe after reset follows no complete frame. It transfers nothing and does not set the receive status bit.
- R8: Status register 0x3F has bit 0 for the transmit copy and bit 1 for the receive transfer. Each bit is set by its event. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R9: A receive transfer while status bit 1 is still set still overwrites 0x18/0x19, and the bit stays set.
- R10: `irq` is high exactly when some status bit is set together with the matching bit of enable register 0x3E.
- R11: Registers 0x24, 0x3E and 0x3F are accessible regardless of the select bit. Any unmapped address reads 0. Only bit 0 of 0x24 is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wr | input | 1 | Write strobe for `wdata` at `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| tx_frame | input | 1 | Marks the first transmit overhead slot of a frame (valid with `tx_slot`) |
| tx_slot | input | 1 | Transmit overhead slot strobe |
| tx_bit | output | 1 | Serial transmit overhead bit |
| rx_frame | input | 1 | Marks the first receive overhead slot of a frame (valid with `rx_slot`) |
| rx_slot | input | 1 | Receive overhead slot strobe |
| rx_bit | input | 1 | Serial receive overhead bit |

## Verification
The hardest state to reach is a collision between software and a frame boundary. This happens when a status clear lands in the same cycle as a transmit copy, or when a receive transfer arrives while software has not yet acknowledged the previous one. The bench drives the slot strobes and the register write from a single task, so the boundary and the write can share one clock edge. It also runs two full receive frames back to back without clearing the status, which produces the overwrite case. Running a receive frame past its last slot, and rewriting the transmit registers in the middle of a frame, cover the remaining buffering corners.

// File: rtl/ovh_pkg.sv
package ovh_pkg;

    localparam int AW = 8;

    localparam logic [AW-1:0] A_SEL = 8'h24;
    localparam logic [AW-1:0] A_IEN = 8'h3E;
    localparam logic [AW-1:0] A_IST = 8'h3F;
    localparam logic [AW-1:0] A_TX0 = 8'h10;
    localparam logic [AW-1:0] A_RX0 = 8'h18;

    typedef struct packed {
        logic rx;
        logic tx;
    } evt_t;

    function automatic logic bank_hit(input logic [AW-1:0] a,
                                      input logic [AW-1:0] base,
                                      input int r);
        return a == (base + AW'(r));
    endfunction

endpackage

// File: rtl/ovh_slot_ctr.sv
module ovh_slot_ctr #(
    parameter int N  = 16,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame,
    input  logic          slot,
    output logic [CW-1:0] idx,
    output logic          in_rng
);

    logic [CW-1:0] cnt_q;

    assign idx    = frame ? '0 : cnt_q;
    assign in_rng = idx < CW'(N);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(N);
        end else if (slot && in_rng) begin
            cnt_q <= idx + CW'(1);
        end
    end

endmodule

// File: rtl/ovh_tx_ser.sv
module ovh_tx_ser #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame,
    input  logic         slot,
    input  logic [N-1:0] user_word,
    output logic         latch,
    output logic         bit_out
);

    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  shadow_q;
    logic [CW-1:0] idx;
    logic          in_rng;

    ovh_slot_ctr #(.N(N)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .frame  (frame),
        .slot   (slot),
        .idx    (idx),
        .in_rng (in_rng)
    );

    assign latch = slot && frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            bit_out  <= 1'b0;
        end else if (slot) begin
            if (frame) begin
                shadow_q <= user_word;
                bit_out  <= user_word[0];
            end else begin
                bit_out  <= in_rng ? shadow_q[idx] : 1'b0;
            end
        end
    end

endmodule

// File: rtl/ovh_rx_des.sv
module ovh_rx_des #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame,
    input  logic         slot,
    input  logic         bit_in,
    output logic         xfer,
    output logic [N-1:0] user_word
);

    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  shadow_q;
    logic [N-1:0]  shadow_d;
    logic          have_q;
    logic [CW-1:0] idx;
    logic          in_rng;

    ovh_slot_ctr #(.N(N)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .frame  (frame),
        .slot   (slot),
        .idx    (idx),
        .in_rng (in_rng)
    );

    assign xfer = slot && frame && have_q;

    always_comb begin
        shadow_d = frame ? '0 : shadow_q;
        if (in_rng) begin
            shadow_d[idx] = bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= '0;
            user_word <= '0;
            have_q    <= 1'b0;
        end else if (slot) begin
            shadow_q <= shadow_d;
            if (frame) begin
                have_q <= 1'b1;
            end
            if (xfer) begin
                user_word <= shadow_q;
            end
        end
    end

endmodule

// File: rtl/ovh_dbuf_regs.sv
module ovh_dbuf_regs
    import ovh_pkg::*;
#(
    parameter int              OH_BITS   = 16,
    parameter int              DW        = 8,
    parameter logic [OH_BITS-1:0] PROT_MASK = 16'h00F0,
    parameter int              IND_POS   = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    input  logic          tx_frame,
    input  logic          tx_slot,
    output logic          tx_bit,
    input  logic          rx_frame,
    input  logic          rx_slot,
    input  logic          rx_bit
);

    localparam int NREG = OH_BITS / DW;
    localparam logic [OH_BITS-1:0] IND_M    = OH_BITS'(1) << IND_POS;
    localparam logic [OH_BITS-1:0] PROT_EFF = PROT_MASK & ~IND_M;
    localparam logic [OH_BITS-1:0] WMASK    = ~PROT_EFF;

    logic [OH_BITS-1:0] tx_user_q;
    logic [OH_BITS-1:0] tx_nxt;
    logic [OH_BITS-1:0] rx_user;
    logic               sel_q;
    evt_t               ien_q;
    evt_t               ist_q;
    evt_t               ist_nxt;
    logic               tx_latch;
    logic               rx_latch;

    ovh_tx_ser #(.N(OH_BITS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .frame     (tx_frame),
        .slot      (tx_slot),
        .user_word (tx_user_q),
        .latch     (tx_latch),
        .bit_out   (tx_bit)
    );

    ovh_rx_des #(.N(OH_BITS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .frame     (rx_frame),
        .slot      (rx_slot),
        .bit_in    (rx_bit),
        .xfer      (rx_latch),
        .user_word (rx_user)
    );

    always_comb begin
        tx_nxt = tx_user_q;
        for (int r = 0; r < NREG; r++) begin
            if (wr && sel_q && bank_hit(addr, A_TX0, r)) begin
                tx_nxt[r*DW +: DW] = (tx_user_q[r*DW +: DW] & ~WMASK[r*DW +: DW])
                                   | (wdata & WMASK[r*DW +: DW]);
            end
        end
    end

    always_comb begin
        ist_nxt = ist_q;
        if (wr && addr == A_IST) begin
            ist_nxt = evt_t'(ist_q & ~wdata[1:0]);
        end
        ist_nxt.tx = ist_nxt.tx | tx_latch;
        ist_nxt.rx = ist_nxt.rx | rx_latch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_user_q <= '0;
            sel_q     <= 1'b0;
            ien_q     <= '0;
            ist_q     <= '0;
        end else begin
            tx_user_q <= tx_nxt;
            ist_q     <= ist_nxt;
            if (wr && addr == A_SEL) begin
                sel_q <= wdata[0];
            end
            if (wr && addr == A_IEN) begin
                ien_q <= evt_t'(wdata[1:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_SEL) begin
            rdata = DW'(sel_q);
        end else if (addr == A_IEN) begin
            rdata = DW'(ien_q);
        end else if (addr == A_IST) begin
            rdata = DW'(ist_q);
        end else if (sel_q) begin
            for (int r = 0; r < NREG; r++) begin
                if (bank_hit(addr, A_TX0, r)) rdata = tx_user_q[r*DW +: DW];
                if (bank_hit(addr, A_RX0, r)) rdata = rx_user[r*DW +: DW];
            end
        end
    end

    assign irq = (ist_q.tx && ien_q.tx) || (ist_q.rx && ien_q.rx);

endmodule

// File: rtl/ovh_dbuf_chk.sv
module ovh_dbuf_chk
    import ovh_pkg::*;
#(
    parameter int                 OH_BITS  = 16,
    parameter int                 DW       = 8,
    parameter logic [OH_BITS-1:0] PROT_EFF = '0
) (
    input logic               clk,
    input logic               rst,
    input logic               wr,
    input logic [AW-1:0]      addr,
    input logic [DW-1:0]      wdata,
    input logic               tx_frame,
    input logic               tx_slot,
    input logic               rx_frame,
    input logic               rx_slot,
    input logic               tx_bit,
    input logic [1:0]         ist,
    input logic               sel,
    input logic [OH_BITS-1:0] tx_user,
    input logic [OH_BITS-1:0] rx_user
);

    // R2
    sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !sel && addr != A_SEL) |=> $stable(tx_user));

    // R3
    prot_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_user & PROT_EFF) == '0);

    // R4
    tx_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_slot && tx_frame) |=> ist[0]);

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_slot |=> $stable(tx_bit));

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_slot && rx_frame) |=> $stable(rx_user));

    // R8
    ist_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ist[0]) |-> $past(wr && addr == A_IST && wdata[0]));

    // R9
    rx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ist[1] && !(wr && addr == A_IST && wdata[1])) |=> ist[1]);

endmodule

bind ovh_dbuf_regs ovh_dbuf_chk #(
    .OH_BITS  (OH_BITS),
    .DW       (DW),
    .PROT_EFF (PROT_EFF)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr),
    .addr     (addr),
    .wdata    (wdata),
    .tx_frame (tx_frame),
    .tx_slot  (tx_slot),
    .rx_frame (rx_frame),
    .rx_slot  (rx_slot),
    .tx_bit   (tx_bit),
    .ist      (ist_q),
    .sel      (sel_q),
    .tx_user  (tx_user_q),
    .rx_user  (rx_user)
);

// File: tb/tb_ovh_dbuf_regs.sv
module tb_ovh_dbuf_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       tx_frame = 1'b0, tx_slot = 1'b0, tx_bit;
    logic       rx_frame = 1'b0, rx_slot = 1'b0, rx_bit = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ovh_dbuf_regs dut (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .tx_frame(tx_frame), .tx_slot(tx_slot), .tx_bit(tx_bit),
        .rx_frame(rx_frame), .rx_slot(rx_slot), .rx_bit(rx_bit)
    );

    // vector: {req[3:0], wr, addr[7:0], wdata[7:0], expected read[7:0]}
    localparam int NV = 17;
    localparam logic [28:0] VEC [NV] = '{
        {4'd1,  1'b0, 8'h24, 8'h00, 8'h00},  // R1 select clear
        {4'd1,  1'b0, 8'h3F, 8'h00, 8'h00},  // R1 status clear
        {4'd1,  1'b0, 8'h3E, 8'h00, 8'h00},  // R1 enable clear
        {4'd2,  1'b1, 8'h10, 8'hFF, 8'h00},  // R2 write without select
        {4'd11, 1'b1, 8'h24, 8'hFF, 8'h01},  // R11 only bit 0 stored
        {4'd2,  1'b0, 8'h10, 8'h00, 8'h00},  // R2 earlier write dropped
        {4'd3,  1'b1, 8'h10, 8'hFF, 8'h2F},  // R3 bits 4,6,7 protected
        {4'd3,  1'b1, 8'h10, 8'hA5, 8'h25},  // R3 bit 5 writable
        {4'd3,  1'b1, 8'h11, 8'h3C, 8'h3C},  // R3 upper byte free
        {4'd1,  1'b0, 8'h18, 8'h00, 8'h00},  // R1 rx regs clear
        {4'd10, 1'b1, 8'h3E, 8'h03, 8'h03},  // R10 enable readback
        {4'd10, 1'b1, 8'h3E, 8'h00, 8'h00},  // R10 enable off
        {4'd11, 1'b0, 8'h55, 8'h00, 8'h00},  // R11 unmapped
        {4'd11, 1'b1, 8'h24, 8'h00, 8'h00},  // R11 select off
        {4'd2,  1'b0, 8'h11, 8'h00, 8'h00},  // R2 read gated
        {4'd11, 1'b1, 8'h24, 8'h01, 8'h01},  // R11 select on
        {4'd2,  1'b0, 8'h11, 8'h00, 8'h3C}   // R2 contents kept
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, {24'h0, rdata}, {24'h0, exp});
    endtask

    task automatic cyc(input logic tf, input logic ts, input logic rf, input logic rs,
                       input logic rb, input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tx_frame = tf; tx_slot = ts; rx_frame = rf; rx_slot = rs; rx_bit = rb;
        wr = w; addr = a; wdata = d;
        @(negedge clk);
        tx_frame = 1'b0; tx_slot = 1'b0; rx_frame = 1'b0; rx_slot = 1'b0; wr = 1'b0;
    endtask

    task automatic wrr(input logic [7:0] a, input logic [7:0] d);
        cyc(0, 0, 0, 0, 0, 1, a, d);
    endtask

    task automatic rx_frame_send(input logic [15:0] w, input logic extra);
        cyc(0, 0, 1, 1, w[0], 0, 8'h00, 8'h00);
        for (int k = 1; k < 16; k++) cyc(0, 0, 0, 1, w[k], 0, 8'h00, 8'h00);
        if (extra) cyc(0, 0, 0, 1, ~w[15], 0, 8'h00, 8'h00);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [15:0] txw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 tx_bit", {31'h0, tx_bit}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) wrr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][28:25], i));
        end

        // R4 R5: transmit copy and serial order, word 0x3C25
        txw = 16'h3C25;
        cyc(1, 1, 0, 0, 0, 0, 8'h00, 8'h00);
        chk("R5 slot0", {31'h0, tx_bit}, {31'h0, txw[0]});
        rd(8'h3F, 8'h01, "R8 tx status set");
        wrr(8'h10, 8'h00);
        chk("R5 hold without strobe", {31'h0, tx_bit}, {31'h0, txw[0]});
        for (int k = 1; k < 16; k++) begin
            cyc(0, 1, 0, 0, 0, 0, 8'h00, 8'h00);
            chk($sformatf("R4 slot%0d", k), {31'h0, tx_bit}, {31'h0, txw[k]});
        end
        cyc(0, 1, 0, 0, 0, 0, 8'h00, 8'h00);
        chk("R5 past last slot", {31'h0, tx_bit}, 32'h0);
        wrr(8'h3F, 8'h00);
        rd(8'h3F, 8'h01, "R8 write 0 keeps");
        // R8 event and clear in the same cycle; new word 0x3C00
        cyc(1, 1, 0, 0, 0, 1, 8'h3F, 8'h01);
        rd(8'h3F, 8'h01, "R8 set beats clear");
        chk("R4 new frame bit0", {31'h0, tx_bit}, 32'h0);
        for (int k = 1; k < 11; k++) cyc(0, 1, 0, 0, 0, 0, 8'h00, 8'h00);
        chk("R5 slot10 new word", {31'h0, tx_bit}, 32'h1);
        wrr(8'h3F, 8'h01);
        rd(8'h3F, 8'h00, "R8 clear");

        // R7 R6: receive
        cyc(0, 0, 1, 1, 1'b1, 0, 8'h00, 8'h00);
        rd(8'h3F, 8'h00, "R7 first boundary no status");
        for (int k = 1; k < 16; k++) cyc(0, 0, 0, 1, 1'b0, 0, 8'h00, 8'h00);
        rd(8'h18, 8'h00, "R7 first boundary no transfer");
        rx_frame_send(16'hB2D1, 1'b1);
        rd(8'h18, 8'h01, "R6 prior frame low");
        rd(8'h19, 8'h00, "R6 prior frame high");
        rd(8'h3F, 8'h02, "R8 rx status");
        rx_frame_send(16'h4E97, 1'b0);
        rd(8'h18, 8'hD1, "R6 low byte");
        rd(8'h19, 8'hB2, "R6 high byte, extra slot dropped");
        wrr(8'h3E, 8'h02);
        chk("R10 irq rx enabled", {31'h0, irq}, 32'h1);
        wrr(8'h3E, 8'h01);
        chk("R10 irq tx only", {31'h0, irq}, 32'h0);
        wrr(8'h3E, 8'h02);
        cyc(0, 0, 1, 1, 1'b0, 0, 8'h00, 8'h00);
        rd(8'h18, 8'h97, "R9 overwrite low");
        rd(8'h19, 8'h4E, "R9 overwrite high");
        rd(8'h3F, 8'h02, "R9 status kept");
        wrr(8'h3F, 8'h02);
        rd(8'h3F, 8'h00, "R8 rx cleared");
        chk("R10 irq off", {31'h0, irq}, 32'h0);

        done = 1;
        summary();
    end

endmodule